// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block turns the system clock into the bit timing of an I2C master. A 7-bit rate setting holds two dividers. One is a linear divider M, from 0 to 15. The other is a power-of-two divider N, from 0 to 7. The first stage counts system clocks up to M+1. The second stage counts the wraps of the first stage up to 2^N. When both stages wrap together, the block issues a one-cycle sub-phase tick. So the tick period is (M+1)·2^N system clocks, and the SCL frequency is the system clock divided by 10·(M+1)·2^N.

Each SCL bit is split into ten sub-phases. SCL is driven low for the first five and released for the last five. A one-cycle SDA update strobe marks the middle of the low half. A slave may stretch the clock by holding the line low after the block releases it; the dividers and the sub-phase counter then wait. The host writes a new rate setting through a write port. The new setting is staged and applied only at a full divider wrap, so a period already in progress always completes at the old rate.

Top module: `scl_rate_gen`

## Requirements
- R1: The rate setting places M in bits 6:3 and N in bits 2:0. While enabled and not stretched, consecutive ticks are (M+1)·2^N clock cycles apart.
- R2: After reset the setting is 7'h44 (M=8, N=4), so ticks are 144 cycles apart if no write occurs.
- R3: For any setting other than M=0,N=0, `tick` is high for exactly one cycle per period.
- R4: `phase` advances by one on every tick and wraps from 9 to 0. It holds between ticks.
- R5: While enabled, `scl_out` is 0 (drive low) for phases 0 to 4 and 1 (released) for phases 5 to 9.
- R6: `sda_upd` pulses only in the cycle where `tick` is high and `phase` has just become 2.
- R7: While `scl_out` is 1 but `scl_in` reads 0, the dividers and `phase` hold, and no tick is issued.
- R8: A setting written while the generator runs takes effect at the next tick. The interval in progress finishes at the old period.
- R9: While `en` is low, `scl_out` is 1, `phase` is 0 and no tick occurs, and a written setting is applied at once. The first tick comes on the L-th clock edge after the edge that first samples `en` high, where L=(M+1)·2^N.
- R10: The extreme settings work: M=0,N=0 ticks every cycle, and M=15,N=7 ticks every 2048 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the generator; low parks SCL released |
| baud_we | input | 1 | Write strobe for the rate setting |
| baud_wdata | input | 7 | New setting, {M[3:0], N[2:0]} |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_out | output | 1 | 0 = drive SCL low, 1 = release |
| tick | output | 1 | One-cycle sub-phase tick |
| phase | output | 4 | Current sub-phase, 0 to 9 |
| sda_upd | output | 1 | Strobe for changing SDA mid-low-half |

## Verification
A wrong count in either divider stage shows up as a wrong gap between `tick` pulses, at the very next tick. An off-by-one setting is therefore caught within one period. A setting applied too early shortens the interval that was in progress, so the R8 case measures that exact interval. A corrupted sub-phase counter shows within one tick, as a skipped `phase` value, an SCL level that does not match the half of the bit, or a misplaced `sda_upd`. A stretch that fails to freeze the state shows as a tick or phase change while `scl_in` is held low.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  localparam int unsigned M_W    = 4;
  localparam int unsigned N_W    = 3;
  localparam int unsigned BAUD_W = M_W + N_W;
  localparam int unsigned C2_W   = (1 << N_W) - 1;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } baud_t;

  // Terminal count of the power-of-two stage: 2^n - 1
  function automatic logic [C2_W-1:0] pow2_last(input logic [N_W-1:0] n);
    logic [C2_W:0] t;
    t    = '0;
    t[0] = 1'b1;
    t    = t << n;
    t    = t - 1'b1;
    return t[C2_W-1:0];
  endfunction
endpackage

// File: rtl/scl_prescale.sv
module scl_prescale
  import scl_rate_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  hold,
  input  baud_t cfg,
  output logic  wrap
);
  logic [M_W-1:0]  lin_q, lin_d;
  logic [C2_W-1:0] pw_q, pw_d;
  logic [C2_W-1:0] pw_last;
  logic            lin_wrap;
  logic            cnt_en;

  always_comb begin
    pw_last  = pow2_last(cfg.n);
    lin_wrap = (lin_q == cfg.m);
    cnt_en   = run && !hold;
    wrap     = cnt_en && lin_wrap && (pw_q == pw_last);
    lin_d    = lin_q;
    pw_d     = pw_q;
    if (!run) begin
      lin_d = '0;
      pw_d  = '0;
    end else if (cnt_en) begin
      if (lin_wrap) begin
        lin_d = '0;
        pw_d  = (pw_q == pw_last) ? '0 : pw_q + 1'b1;
      end else begin
        lin_d = lin_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q <= '0;
      pw_q  <= '0;
    end else begin
      lin_q <= lin_d;
      pw_q  <= pw_d;
    end
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int unsigned PHASES = 10,
  localparam int unsigned PH_W  = $clog2(PHASES),
  localparam int unsigned HALF  = PHASES / 2,
  localparam int unsigned SDA_AT = HALF / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            step,
  output logic [PH_W-1:0] phase,
  output logic            scl_rel,
  output logic            tick,
  output logic            sda_upd
);
  logic [PH_W-1:0] ph_q, ph_d;
  logic            rel_q, rel_d;
  logic            tick_q, sda_q;

  always_comb begin
    ph_d = ph_q;
    if (!run)
      ph_d = '0;
    else if (step)
      ph_d = (ph_q == PH_W'(PHASES - 1)) ? '0 : ph_q + 1'b1;
    rel_d = !(run && (ph_d < PH_W'(HALF)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      rel_q  <= 1'b1;
      tick_q <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      rel_q  <= rel_d;
      tick_q <= step;
      sda_q  <= step && (ph_q == PH_W'(SDA_AT - 1));
    end
  end

  assign phase   = ph_q;
  assign scl_rel = rel_q;
  assign tick    = tick_q;
  assign sda_upd = sda_q;
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int unsigned PHASES   = 10,
  parameter logic [6:0]  BAUD_RST = 7'h44,
  localparam int unsigned PH_W    = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            baud_we,
  input  logic [6:0]      baud_wdata,
  input  logic            scl_in,
  output logic            scl_out,
  output logic            tick,
  output logic [PH_W-1:0] phase,
  output logic            sda_upd
);
  baud_t baud_pend_q, baud_pend_d;
  baud_t baud_act_q, baud_act_d;
  logic  act_q;
  logic  stall;
  logic  wrap;
  logic  scl_rel;

  // Staged setting: applied at a full wrap or while idle
  always_comb begin
    baud_pend_d = baud_we ? baud_t'(baud_wdata) : baud_pend_q;
    baud_act_d  = baud_act_q;
    if (!act_q || wrap)
      baud_act_d = baud_pend_d;
    stall = act_q && scl_rel && !scl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_pend_q <= baud_t'(BAUD_RST);
      baud_act_q  <= baud_t'(BAUD_RST);
      act_q       <= 1'b0;
    end else begin
      baud_pend_q <= baud_pend_d;
      baud_act_q  <= baud_act_d;
      act_q       <= en;
    end
  end

  scl_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (act_q),
    .hold (stall),
    .cfg  (baud_act_q),
    .wrap (wrap)
  );

  scl_phase_seq #(.PHASES(PHASES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (act_q),
    .step   (wrap),
    .phase  (phase),
    .scl_rel(scl_rel),
    .tick   (tick),
    .sda_upd(sda_upd)
  );

  assign scl_out = scl_rel;
endmodule

// File: rtl/scl_rate_chk.sv
module scl_rate_chk #(
  parameter int unsigned PHASES = 10,
  localparam int unsigned PH_W  = $clog2(PHASES),
  localparam int unsigned HALF  = PHASES / 2,
  localparam int unsigned SDA_AT = HALF / 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            act_q,
  input logic [6:0]      baud_act,
  input logic            scl_in,
  input logic            scl_out,
  input logic            tick,
  input logic [PH_W-1:0] phase,
  input logic            sda_upd
);
  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && baud_act != 7'd0) |=> !tick);

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (phase == (($past(phase) == PH_W'(PHASES - 1)) ? '0 : $past(phase) + 1'b1)));

  // R5
  scl_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |-> (scl_out == (phase >= PH_W'(HALF))));

  // R6
  sda_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_upd |-> (tick && phase == PH_W'(SDA_AT)));

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && scl_out && !scl_in) |=> ($stable(phase) && !tick));

  // R9
  idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |=> (scl_out && !tick && phase == '0));
endmodule

bind scl_rate_gen scl_rate_chk #(.PHASES(PHASES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .act_q   (act_q),
  .baud_act(baud_act_q),
  .scl_in  (scl_in),
  .scl_out (scl_out),
  .tick    (tick),
  .phase   (phase),
  .sda_upd (sda_upd)
);

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
  logic       clk;
  logic       rst_n;
  logic       en;
  logic       baud_we;
  logic [6:0] baud_wdata;
  logic       stretch;
  logic       scl_in;
  logic       scl_out;
  logic       tick;
  logic [3:0] phase;
  logic       sda_upd;

  int checks = 0;
  int fails  = 0;
  int q_exp[$];
  bit mon_en   = 0;
  bit have_last = 0;
  int cyc = 0;
  int last_cyc = 0;
  int prev_ph = 0;
  bit done = 0;

  scl_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .baud_we(baud_we),
    .baud_wdata(baud_wdata), .scl_in(scl_in), .scl_out(scl_out),
    .tick(tick), .phase(phase), .sda_upd(sda_upd)
  );

  assign scl_in = scl_out & ~stretch;

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: interval scoreboard and per-tick phase, SCL and SDA checks
  always @(negedge clk) begin
    cyc++;
    if (rst_n && tick) begin
      chk(phase == ((prev_ph + 1) % 10), "R4 phase step", phase, (prev_ph + 1) % 10);
      chk(scl_out == (phase >= 5), "R5 scl level", scl_out, phase >= 5);
      if (mon_en) begin
        if (have_last && q_exp.size() > 0) begin
          int e;
          e = q_exp.pop_front();
          chk(cyc - last_cyc == e, "R1 tick interval", cyc - last_cyc, e);
        end
        have_last = 1;
        last_cyc  = cyc;
      end
    end
    if (rst_n && (tick || sda_upd))
      chk(sda_upd == (tick && phase == 2), "R6 sda strobe", sda_upd, tick && phase == 2);
    prev_ph = phase;
  end

  task automatic step_cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic write_baud(input int m, input int n);
    baud_wdata = 7'((m << 3) | n);
    baud_we = 1;
    step_cyc(1);
    baud_we = 0;
  endtask

  task automatic wait_drain();
    while (q_exp.size() > 0) step_cyc(1);
  endtask

  // Driver: configure, push expected intervals, run
  task automatic run_cfg(input int m, input int n, input int k, input string req);
    int len;
    int c;
    len = (m + 1) << n;
    en = 0;
    step_cyc(2);
    write_baud(m, n);
    have_last = 0;
    for (int i = 0; i < k; i++) q_exp.push_back(len);
    en = 1;
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!tick);
    // R9: first tick lands L edges after the sampling edge
    chk(c == len + 2, {req, " / R9 first tick"}, c, len + 2);
    #2;
    wait_drain();
    en = 0;
    step_cyc(3);
  endtask

  initial begin
    int hold_bad;
    int c;
    rst_n = 0; en = 0; baud_we = 0; baud_wdata = 0; stretch = 0;
    step_cyc(3);
    rst_n = 1;
    step_cyc(2);
    chk(scl_out == 1, "R9 reset scl", scl_out, 1);
    chk(tick == 0, "R9 reset tick", tick, 0);
    chk(phase == 0, "R9 reset phase", phase, 0);
    mon_en = 1;

    // R2: default setting, no write
    have_last = 0;
    for (int i = 0; i < 3; i++) q_exp.push_back(144);
    en = 1;
    wait_drain();
    en = 0;
    step_cyc(3);

    // R1: several settings
    run_cfg(2, 1, 12, "R1 m2n1");
    run_cfg(5, 3, 4, "R1 m5n3");
    run_cfg(1, 0, 12, "R1 m1n0");
    // R10: extremes
    run_cfg(0, 0, 25, "R10 m0n0");
    run_cfg(15, 7, 2, "R10 m15n7");

    // R9: idle holds SCL released, no ticks, phase 0
    hold_bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (tick || !scl_out || phase != 0) hold_bad++;
      step_cyc(1);
    end
    chk(hold_bad == 0, "R9 idle parked", hold_bad, 0);

    // R8: mid-period write waits for the next wrap
    write_baud(3, 1);
    have_last = 0;
    q_exp.push_back(8); q_exp.push_back(8);
    q_exp.push_back(20); q_exp.push_back(20);
    en = 1;
    while (q_exp.size() > 3) step_cyc(1);
    step_cyc(1);
    write_baud(4, 2);
    wait_drain();
    en = 0;
    step_cyc(3);

    // R7: slave stretch freezes phase and ticks
    mon_en = 0;
    write_baud(9, 0);
    en = 1;
    while (phase != 5) step_cyc(1);
    stretch = 1;
    hold_bad = 0;
    step_cyc(1);
    for (int i = 0; i < 30; i++) begin
      if (phase != 5 || tick) hold_bad++;
      step_cyc(1);
    end
    chk(hold_bad == 0, "R7 stretch hold", hold_bad, 0);
    stretch = 0;
    c = 0;
    while (phase == 5 && c < 40) begin
      step_cyc(1);
      c++;
    end
    chk(phase == 6, "R7 resume after stretch", phase, 6);
    en = 0;
    step_cyc(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule